// File: doc/BRIEF.md
# Marching-Zero SRAM Functional Test Sequencer

This block drives a functional test of a small static RAM with eight locations of one byte each. After a start pulse it runs a write pass. Every location, in ascending address order, gets a byte that is all ones except for one zero. The position of that zero moves one place toward the least significant bit for each address step. During this pass the block drives the data bus and raises the write strobe.

After one idle cycle to turn the bus around, the block runs a read pass over the same addresses. In this pass it releases the data bus and raises the read strobe. Each byte read back is compared bit for bit with the byte that was written to that address.

When the read pass is finished, the block raises a done flag and holds it. It reports pass or fail, and for a failure it also reports the address and the byte observed at the first mismatch. The block is meant to sit between a test pattern controller and the memory pins. The memory must return read data in the cycle after the address is presented.

Top module: `mzero_seq`

## Requirements
- R1: After reset the outputs are idle: `we_o`, `oe_o`, `drv_en_o`, `done_o` and `pass_o` are 0, `addr_o` is 0, and `wr_data_o`, `fail_addr_o` and `fail_data_o` are 0.
- R2: In the first 8 cycles after an accepted start, `we_o`=1, `oe_o`=0 and `drv_en_o`=1, and `addr_o` steps 0,1,...,7, one address per cycle.
- R3: During the write pass, `wr_data_o` at address a is 8'hFF with bit (7-a) cleared, where bit 7 is the MSB. Address 0 gets 8'h7F and address 7 gets 8'hFE.
- R4: Exactly one cycle with `we_o`=0, `oe_o`=0 and `drv_en_o`=0 separates the last write from the first read.
- R5: The next 8 cycles are the read pass, with `we_o`=0, `oe_o`=1 and `drv_en_o`=0, and `addr_o` steps 0..7.
- R6: The block samples `rd_data_i` in the cycle after the cycle in which a read address is shown. All 8 bits are compared with the R3 byte for that address. A mismatch on the read of address a clears `pass_o` on the edge that ends that sampling cycle.
- R7: `done_o` rises in the cycle after the sampling cycle of address 7, which is the 19th cycle after the start edge. It then stays at 1 until the next start pulse.
- R8: `pass_o` is 1 when `done_o` rises if every read byte matched. `pass_o` is 0 if any byte differed.
- R9: `fail_addr_o` and `fail_data_o` capture the address and the observed byte of the first mismatch only. Later mismatches in the same run leave them unchanged.
- R10: A start pulse that arrives while the test is running (write, turnaround, read or sampling of the last read) has no effect on the sequence.
- R11: A start pulse given in idle or while `done_o` is 1 begins a new run. In the first cycle of that run, `done_o` is 0, `pass_o` is 1 and both fail fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, one cycle |
| rd_data_i | input | 8 | Byte returned by the memory, valid the cycle after a read address |
| addr_o | output | 3 | Memory address |
| wr_data_o | output | 8 | Byte driven onto the data bus during writes |
| we_o | output | 1 | Write strobe |
| oe_o | output | 1 | Read strobe |
| drv_en_o | output | 1 | Tester data-bus driver enable, 0 means tristate |
| done_o | output | 1 | Test finished, held until next start |
| pass_o | output | 1 | No mismatch seen in this run |
| fail_addr_o | output | 3 | Address of the first mismatch |
| fail_data_o | output | 8 | Byte observed at the first mismatch |

## Verification
The assertions assume that `start_i` is a clean synchronous level and that reset is held for at least one edge before the first start. They make no assumption about `rd_data_i`. The comparator is checked only against its own latched state. The bench models the memory as a register file. The model returns the addressed byte on the edge after a read strobe and XORs it with a per-address fault mask, which keeps read data on the one-cycle latency the sequencer expects. Start pulses are given only from idle or done, except where the bench deliberately injects them mid-run.

// File: rtl/mzero_pkg.sv
// Package: shared types for the marching-zero test sequencer.
// Assumes nothing beyond a SystemVerilog-2017 compiler.
package mzero_pkg;
    // Sequencer phases; order carries no meaning outside the controller.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_TURN,
        ST_READ,
        ST_DRAIN,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/mzero_ctrl.sv
// Module: mzero_ctrl
// Walks the test phases (write pass, one turnaround cycle, read pass, one
// drain cycle for the last read sample, then done) and produces the address,
// the walking-zero byte for that address and the strobes.
// Assumes 2**ADDR_W <= DATA_W so every address owns a distinct zero position.
module mzero_ctrl
    import mzero_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] pattern_o,
    output logic              we_o,
    output logic              oe_o,
    output logic              drv_en_o,
    output logic              launch_o,
    output logic              done_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
    localparam logic [DATA_W-1:0] MSB_ONE = {1'b1, {(DATA_W-1){1'b0}}};

    seq_state_t        state_q;
    logic [ADDR_W-1:0] addr_q;

    // Accept a start only when no run is in progress.
    assign launch_o = start_i && (state_q == ST_IDLE || state_q == ST_DONE);

    // Phase and address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (launch_o) begin
                        state_q <= ST_WRITE;
                        addr_q  <= '0;
                    end
                end
                ST_WRITE: begin
                    if (addr_q == LAST_ADDR) begin
                        state_q <= ST_TURN;
                        addr_q  <= '0;
                    end else begin
                        addr_q <= addr_q + 1'b1;
                    end
                end
                ST_TURN:  state_q <= ST_READ;
                ST_READ: begin
                    if (addr_q == LAST_ADDR) begin
                        state_q <= ST_DRAIN;
                        addr_q  <= '0;
                    end else begin
                        addr_q <= addr_q + 1'b1;
                    end
                end
                ST_DRAIN: state_q <= ST_DONE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Walking-zero byte: the single zero moves down from the MSB with the address.
    assign pattern_o = ~(MSB_ONE >> addr_q);

    // Strobes decoded from the phase.
    assign addr_o   = addr_q;
    assign we_o     = (state_q == ST_WRITE);
    assign oe_o     = (state_q == ST_READ);
    assign drv_en_o = (state_q == ST_WRITE);
    assign done_o   = (state_q == ST_DONE);

    // R2
    wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_o && addr_o != LAST_ADDR) |=> (we_o && addr_o == ADDR_W'($past(addr_o) + 1'b1)));
    // R5
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o && addr_o != LAST_ADDR) |=> (oe_o && addr_o == ADDR_W'($past(addr_o) + 1'b1)));
    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);
    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (we_o || oe_o)) |=> !(we_o && addr_o == '0));
endmodule

// File: rtl/mzero_cmp.sv
// Module: mzero_cmp
// Checks read-back bytes. It captures the expected byte and address while a
// read is shown, compares the memory's byte one cycle later, and keeps the
// first mismatch.
// Assumes the memory returns data exactly one cycle after the read address.
module mzero_cmp #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  logic              rd_strobe_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] exp_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              pass_o,
    output logic [ADDR_W-1:0] fail_addr_o,
    output logic [DATA_W-1:0] fail_data_o
);
    logic              valid_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] exp_q;
    logic              pass_q;
    logic [ADDR_W-1:0] fail_addr_q;
    logic [DATA_W-1:0] fail_data_q;
    logic              mismatch;

    // One-cycle pipeline that lines the expectation up with returning data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
            exp_q   <= '0;
        end else begin
            valid_q <= rd_strobe_i;
            if (rd_strobe_i) begin
                addr_q <= addr_i;
                exp_q  <= exp_i;
            end
        end
    end

    assign mismatch = valid_q && (rd_data_i != exp_q);

    // Verdict and first-failure record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_q      <= 1'b0;
            fail_addr_q <= '0;
            fail_data_q <= '0;
        end else if (launch_i) begin
            pass_q      <= 1'b1;
            fail_addr_q <= '0;
            fail_data_q <= '0;
        end else if (mismatch && pass_q) begin
            pass_q      <= 1'b0;
            fail_addr_q <= addr_q;
            fail_data_q <= rd_data_i;
        end
    end

    assign pass_o      = pass_q;
    assign fail_addr_o = fail_addr_q;
    assign fail_data_o = fail_data_q;

    // R8
    pass_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass_o && !launch_i) |=> !pass_o);
    // R9
    first_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass_o && !launch_i) |=> ($stable(fail_addr_o) && $stable(fail_data_o)));
    // R6
    fail_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pass_o) |-> (fail_data_o != $past(exp_q)));
endmodule

// File: rtl/mzero_seq.sv
// Module: mzero_seq (top)
// Marching-zero functional test for a byte-wide, eight-location static RAM:
// a write pass, one turnaround cycle, and a read pass with per-byte compare.
// Assumes a synchronous memory with one cycle of read latency.
module mzero_seq #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              we_o,
    output logic              oe_o,
    output logic              drv_en_o,
    output logic              done_o,
    output logic              pass_o,
    output logic [ADDR_W-1:0] fail_addr_o,
    output logic [DATA_W-1:0] fail_data_o
);
    logic [DATA_W-1:0] pattern;
    logic              launch;

    mzero_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .addr_o    (addr_o),
        .pattern_o (pattern),
        .we_o      (we_o),
        .oe_o      (oe_o),
        .drv_en_o  (drv_en_o),
        .launch_o  (launch),
        .done_o    (done_o)
    );

    mzero_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_i    (launch),
        .rd_strobe_i (oe_o),
        .addr_i      (addr_o),
        .exp_i       (pattern),
        .rd_data_i   (rd_data_i),
        .pass_o      (pass_o),
        .fail_addr_o (fail_addr_o),
        .fail_data_o (fail_data_o)
    );

    // Drive the bus only while writing; zero otherwise.
    assign wr_data_o = drv_en_o ? pattern : '0;

    // R4
    turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_o) |-> (!oe_o && !drv_en_o));
    // R4
    turn_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_o) |=> oe_o);
    // R5
    no_contend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_o |-> !drv_en_o);
    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_o && oe_o));
endmodule

// File: tb/test_mzero_seq.sv
// Bench for mzero_seq: a register-file memory with a per-address read fault
// mask, swept over every single-bit fault position.
module test_mzero_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] rd_data_i;
    logic [2:0] addr_o;
    logic [7:0] wr_data_o;
    logic       we_o, oe_o, drv_en_o, done_o, pass_o;
    logic [2:0] fail_addr_o;
    logic [7:0] fail_data_o;

    logic [7:0] mem  [8];
    logic [7:0] flip [8];
    int nchk = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    mzero_seq i_mzero_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_data_i(rd_data_i),
        .addr_o(addr_o), .wr_data_o(wr_data_o), .we_o(we_o), .oe_o(oe_o),
        .drv_en_o(drv_en_o), .done_o(done_o), .pass_o(pass_o),
        .fail_addr_o(fail_addr_o), .fail_data_o(fail_data_o)
    );

    // Memory model: write on strobe, read data one edge later with faults.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data_i <= '0;
        else begin
            if (we_o && drv_en_o) mem[addr_o] <= wr_data_o;
            if (oe_o) rd_data_i <= mem[addr_o] ^ flip[addr_o];
        end
    end

    function automatic logic [7:0] pat(input int a);
        return 8'hFF ^ (8'h80 >> a);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One full run; poke injects start pulses mid-run.
    task automatic run(input bit poke);
        int first = -1;
        for (int a = 0; a < 8; a++) if (first < 0 && flip[a] != 0) first = a;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        for (int k = 0; k <= 18; k++) begin
            if (k == 0) begin
                chk("R11 done clr", done_o, 0);
                chk("R11 pass set", pass_o, 1);
                chk("R11 fail clr", {fail_addr_o, fail_data_o}, 0);
            end
            if (k < 8) begin
                chk("R2 strobes", {we_o, oe_o, drv_en_o}, 3'b101);
                chk("R2 addr", addr_o, k);
                chk("R3 wdata", wr_data_o, pat(k));
            end else if (k == 8) begin
                chk("R4 turn", {we_o, oe_o, drv_en_o}, 3'b000);
            end else if (k <= 16) begin
                chk("R5 strobes", {we_o, oe_o, drv_en_o}, 3'b010);
                chk("R5 addr", addr_o, k - 9);
            end else if (k == 17) begin
                chk("R7 not yet done", done_o, 0);
            end else begin
                chk("R7 done", done_o, 1);
                chk("R8 pass", pass_o, (first < 0) ? 1 : 0);
                chk("R9 fail addr", fail_addr_o, (first < 0) ? 0 : first);
                chk("R9 fail data", fail_data_o, (first < 0) ? 0 : (pat(first) ^ flip[first]));
            end
            if (first >= 0 && k == first + 10) chk("R6 pass before sample", pass_o, 1);
            if (first >= 0 && k == first + 11) chk("R6 pass after sample", pass_o, 0);
            start_i = poke && (k == 3 || k == 12 || k == 17);
            @(negedge clk);
        end
        start_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        for (int a = 0; a < 8; a++) begin flip[a] = '0; mem[a] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 strobes", {we_o, oe_o, drv_en_o, done_o, pass_o}, 0);
        chk("R1 addr/data", {addr_o, wr_data_o}, 0);
        chk("R1 fail", {fail_addr_o, fail_data_o}, 0);

        run(1'b0);                       // clean run
        run(1'b1);                       // R10: mid-run starts ignored
        repeat (5) @(negedge clk);
        chk("R7 done held", done_o, 1);
        chk("R8 pass held", pass_o, 1);

        // Sweep every single-bit read fault at every address.
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                flip[a] = 8'h01 << b;
                run(1'b0);
                flip[a] = '0;
            end
        end

        // R9: two faulty addresses, only the first is recorded.
        flip[2] = 8'h10; flip[5] = 8'hFF;
        run(1'b0);
        flip[2] = '0; flip[5] = '0;

        run(1'b0);                       // R11: clean restart after failure
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule